// File: doc/BRIEF.md
# Six-bit minifloat adder

This block adds two numbers held in a tiny six-bit floating-point word. Each word has a sign bit, a two-bit biased exponent and a three-bit fraction that sits behind an implied leading one. The format has no native zero, so two otherwise-valid patterns are set aside to mean +0 and -0. Two operands go in and their rounded sum comes out one clock later. Alongside the sum are two flags: one for a result too large for the format, and one for a non-zero result too small to represent.

Inside, the block first bypasses zero operands. It then orders the operands by magnitude and shifts the smaller significand right so that both share the larger exponent. Next it adds the significands, or subtracts them when the signs differ. A leading-one search normalizes the raw result in either direction, and the block rounds to three fraction bits, to nearest with ties to even. Finally the rounded exponent is checked against the representable range.

Top module: `mf_add6`

## Requirements
- R1: Word layout is bit 5 sign, bits 4:3 exponent code, bits 2:0 fraction f. A word's value is (-1)^sign × (1 + f/8) × 2^(code−1), so codes 00, 01, 10 and 11 scale by 0.5, 1, 2 and 4. The result and flags for operands present before a rising clock edge appear after that edge and hold until the next one.
- R2: While rst_n is low, `sum`, `ovf` and `udf` read all zeros.
- R3: Patterns 000000 (+0) and 100000 (−0) are zero operands. With exactly one zero operand, `sum` equals the other operand unchanged and both flags are low. With two zero operands, `sum` is a zero whose sign is the AND of the two signs.
- R4: Operands of equal sign give their magnitudes' sum, aligned to the larger exponent. Example: 001111 + 010010 gives 011001.
- R5: The exact sum is rounded to three fraction bits, to nearest, with ties going to an even fraction. Examples: 000001 + 001011 (exact 1.9375) gives 010000, and 001000 + 001001 (exact 2.125) gives 010000.
- R6: With opposite signs, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand and is normalized left when leading bits cancel. Example: 001000 + 110001 gives 101010.
- R7: Operands of equal magnitude and opposite sign give exactly 000000, with both flags low.
- R8: When the rounded magnitude exceeds 7.5, `sum` saturates to the largest magnitude (bits 4:0 all ones) with the result's sign, and `ovf` is high. A sum of 7.5625 rounds to 7.5 without overflow.
- R9: A non-zero exact result whose rounded magnitude is 0.5 or less gives a zero carrying the result's sign, and `udf` is high. An exact result of 0.5625 is delivered as 000001 with no flag.
- R10: `ovf` and `udf` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; result registered on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 6 | First operand word |
| op_b | input | 6 | Second operand word |
| sum | output | 6 | Rounded sum word |
| ovf | output | 1 | Result magnitude exceeded the largest representable value |
| udf | output | 1 | Non-zero result too small to represent, flushed to signed zero |

## Verification
The hardest cases to reach are the ones where a subtraction cancels several leading bits and the normalized value then lands exactly halfway between two representable words. That is where the left shift, the guard and sticky bits and the tie-to-even decision all act at once. Directed operand pairs are chosen so that their exact difference sits on such midpoints and on the 0.5 and 7.5 range edges. A sweep over all 4096 operand pairs, compared against an independent nearest-value search over the representable set, then reaches every alignment distance and cancellation depth.

// File: rtl/mf_pkg.sv
package mf_pkg;

    // Default format geometry
    localparam int MF_EXP_W  = 2;
    localparam int MF_FRAC_W = 3;

    // Significand operation selected by the operand signs
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_kind_e;

endpackage

// File: rtl/mf_unpack.sv
module mf_unpack #(
    parameter int EXP_W  = mf_pkg::MF_EXP_W,
    parameter int FRAC_W = mf_pkg::MF_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  exp,
    output logic [FRAC_W-1:0] frac,
    output logic              is_zero
);

    always_comb begin
        sign    = word[WORD_W-1];
        exp     = word[WORD_W-2 -: EXP_W];
        frac    = word[FRAC_W-1:0];
        // Smallest-magnitude pattern is reserved as zero, either sign
        is_zero = (word[WORD_W-2:0] == '0);
    end

endmodule

// File: rtl/mf_align.sv
module mf_align #(
    parameter int EXP_W  = mf_pkg::MF_EXP_W,
    parameter int FRAC_W = mf_pkg::MF_FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int EXT   = (1 << EXP_W) - 1,
    localparam int ALN_W = SIG_W + EXT,
    localparam int SUM_W = ALN_W + 1
) (
    input  logic              sa,
    input  logic [EXP_W-1:0]  ea,
    input  logic [FRAC_W-1:0] fa,
    input  logic              sb,
    input  logic [EXP_W-1:0]  eb,
    input  logic [FRAC_W-1:0] fb,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [SUM_W-1:0]  res_mag
);
    import mf_pkg::*;

    logic              a_big;
    logic [EXP_W-1:0]  big_e, small_e, shamt;
    logic [FRAC_W-1:0] big_f, small_f;
    logic [ALN_W-1:0]  big_al, small_al;
    op_kind_e          kind;

    always_comb begin
        // Ordering by packed {exp, frac} is ordering by magnitude
        a_big   = ({ea, fa} >= {eb, fb});
        big_e   = a_big ? ea : eb;
        big_f   = a_big ? fa : fb;
        small_e = a_big ? eb : ea;
        small_f = a_big ? fb : fa;
        shamt   = big_e - small_e;
        kind    = (sa ^ sb) ? OP_SUB : OP_ADD;

        // Extension bits wide enough that the right shift loses nothing
        big_al   = {1'b1, big_f, {EXT{1'b0}}};
        small_al = {1'b1, small_f, {EXT{1'b0}}} >> shamt;

        case (kind)
            OP_SUB:  res_mag = {1'b0, big_al} - {1'b0, small_al};
            default: res_mag = {1'b0, big_al} + {1'b0, small_al};
        endcase

        res_sign = a_big ? sa : sb;
        res_exp  = big_e;
    end

endmodule

// File: rtl/mf_round.sv
module mf_round #(
    parameter int EXP_W  = mf_pkg::MF_EXP_W,
    parameter int FRAC_W = mf_pkg::MF_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT    = (1 << EXP_W) - 1,
    localparam int ALN_W  = SIG_W + EXT,
    localparam int SUM_W  = ALN_W + 1,
    localparam int LD_W   = $clog2(SUM_W),
    localparam int EX_W   = $clog2((1 << EXP_W) + SUM_W + 1) + 1,
    localparam int LOW_N  = SUM_W - 2 - FRAC_W,
    localparam int BASE   = ALN_W - 1,
    localparam int TOP_EX = BASE + (1 << EXP_W) - 1
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [SUM_W-1:0]  mag,
    output logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic              udf
);

    localparam logic [LD_W-1:0]  TOPIDX   = LD_W'(SUM_W - 1);
    localparam logic [SUM_W-1:0] LOW_MASK = {{(SUM_W-LOW_N){1'b0}}, {LOW_N{1'b1}}};

    logic [LD_W-1:0]   lead;
    logic [SUM_W-1:0]  norm;
    logic [FRAC_W-1:0] keep, frac_r;
    logic              guard, sticky, rnd_up, carry;
    logic [EX_W-1:0]   ex2, ex_off;

    always_comb begin
        // Leading-one position: highest set bit wins
        lead = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (mag[i]) lead = LD_W'(i);
        end

        norm   = mag << (TOPIDX - lead);
        keep   = norm[SUM_W-2 -: FRAC_W];
        guard  = norm[LOW_N];
        sticky = |(norm & LOW_MASK);
        rnd_up = guard & (sticky | keep[0]);
        {carry, frac_r} = {1'b0, keep} + {{FRAC_W{1'b0}}, rnd_up};

        ex2    = {{(EX_W-EXP_W){1'b0}}, exp_in}
               + {{(EX_W-LD_W){1'b0}}, lead}
               + {{(EX_W-1){1'b0}}, carry};
        ex_off = ex2 - EX_W'(BASE);

        word = '0;
        ovf  = 1'b0;
        udf  = 1'b0;
        if (mag == '0) begin
            word = '0;
        end else if (ex2 > EX_W'(TOP_EX)) begin
            word = {sign, {(WORD_W-1){1'b1}}};
            ovf  = 1'b1;
        end else if (ex2 < EX_W'(BASE)) begin
            word = {sign, {(WORD_W-1){1'b0}}};
            udf  = 1'b1;
        end else if ((ex_off[EXP_W-1:0] == '0) && (frac_r == '0)) begin
            // Would encode the pattern reserved for zero
            word = {sign, {(WORD_W-1){1'b0}}};
            udf  = 1'b1;
        end else begin
            word = {sign, ex_off[EXP_W-1:0], frac_r};
        end
    end

endmodule

// File: rtl/mf_add6.sv
module mf_add6 #(
    parameter int EXP_W  = mf_pkg::MF_EXP_W,
    parameter int FRAC_W = mf_pkg::MF_FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SUM_W  = FRAC_W + 1 + (1 << EXP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] sum,
    output logic              ovf,
    output logic              udf
);

    typedef struct packed {
        logic [WORD_W-1:0] sum;
        logic              ovf;
        logic              udf;
    } res_t;

    logic [WORD_W-1:0] ops   [2];
    logic [1:0]        sgn, zr;
    logic [EXP_W-1:0]  exps  [2];
    logic [FRAC_W-1:0] fracs [2];

    logic              al_sign;
    logic [EXP_W-1:0]  al_exp;
    logic [SUM_W-1:0]  al_mag;
    logic [WORD_W-1:0] rn_word;
    logic              rn_ovf, rn_udf;

    res_t st_d, st_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        mf_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word    (ops[g]),
            .sign    (sgn[g]),
            .exp     (exps[g]),
            .frac    (fracs[g]),
            .is_zero (zr[g])
        );
    end

    mf_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sa       (sgn[0]),
        .ea       (exps[0]),
        .fa       (fracs[0]),
        .sb       (sgn[1]),
        .eb       (exps[1]),
        .fb       (fracs[1]),
        .res_sign (al_sign),
        .res_exp  (al_exp),
        .res_mag  (al_mag)
    );

    mf_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign   (al_sign),
        .exp_in (al_exp),
        .mag    (al_mag),
        .word   (rn_word),
        .ovf    (rn_ovf),
        .udf    (rn_udf)
    );

    always_comb begin
        st_d.sum = rn_word;
        st_d.ovf = rn_ovf;
        st_d.udf = rn_udf;
        if (zr[0] && zr[1]) begin
            st_d.sum = {sgn[0] & sgn[1], {(WORD_W-1){1'b0}}};
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end else if (zr[0]) begin
            st_d.sum = op_b;
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end else if (zr[1]) begin
            st_d.sum = op_a;
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.sum;
    assign ovf = st_q.ovf;
    assign udf = st_q.udf;

endmodule

// File: rtl/mf_add6_chk.sv
module mf_add6_chk #(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] sum,
    input logic              ovf,
    input logic              udf
);

    localparam logic [WORD_W-1:0] SIGN_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    // R10: the two flags are mutually exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && udf));

    // R8: overflow always comes with the saturated magnitude
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sum[WORD_W-2:0] == {(WORD_W-1){1'b1}}));

    // R9: underflow always comes with a zero pattern
    a_r9_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        udf |-> (sum[WORD_W-2:0] == '0));

    // R3: a single zero operand passes the other one through
    a_r3_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a[WORD_W-2:0] == '0) && (op_b[WORD_W-2:0] != '0))
        |=> (sum == $past(op_b)) && !ovf && !udf);

    // R7: equal magnitudes of opposite sign cancel to +0
    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a[WORD_W-2:0] != '0) && (op_a == (op_b ^ SIGN_BIT)))
        |=> (sum == '0) && !ovf && !udf);

endmodule

bind mf_add6 mf_add6_chk #(.WORD_W(WORD_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sum   (sum),
    .ovf   (ovf),
    .udf   (udf)
);

// File: tb/tb_mf_add6.sv
`timescale 1ns/1ps
module tb_mf_add6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op_a = 6'b001111;
    logic [5:0] op_b = 6'b010010;
    logic [5:0] sum;
    logic       ovf, udf;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    mf_add6 dut (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .sum   (sum),
        .ovf   (ovf),
        .udf   (udf)
    );

    // Magnitude in units of 1/16; reserved zero patterns give 0
    function automatic int mag16(input logic [5:0] c);
        if (c[4:0] == 5'd0) return 0;
        return (8 + int'(c[2:0])) << int'(c[4:3]);
    endfunction

    // Returns {sum, ovf, udf} from the requirement text alone
    function automatic logic [7:0] ref_add(input logic [5:0] a, input logic [5:0] b);
        int va, vb, t, m, bd, be, bf, c, d;
        logic s;
        bit za, zb;
        za = (a[4:0] == 5'd0);
        zb = (b[4:0] == 5'd0);
        if (za && zb) return {a[5] & b[5], 5'd0, 2'b00};
        if (za) return {b, 2'b00};
        if (zb) return {a, 2'b00};
        va = a[5] ? -mag16(a) : mag16(a);
        vb = b[5] ? -mag16(b) : mag16(b);
        t  = va + vb;
        if (t == 0) return 8'd0;
        s = (t < 0);
        m = s ? -t : t;
        if (m >= 124) return {s, 5'h1f, 2'b10};
        if (m <= 8)   return {s, 5'h00, 2'b01};
        bd = 1000; be = 0; bf = 0;
        for (int e = 0; e < 4; e++) begin
            for (int f = 0; f < 8; f++) begin
                if (e == 0 && f == 0) continue;
                c = (8 + f) << e;
                d = (m > c) ? m - c : c - m;
                if (d < bd || (d == bd && (f % 2) == 0)) begin
                    bd = d; be = e; bf = f;
                end
            end
        end
        return {s, be[1:0], bf[2:0], 2'b00};
    endfunction

    task automatic check(input string req, input logic [5:0] a, input logic [5:0] b,
                         input logic [7:0] exp_v);
        logic [7:0] got;
        got = {sum, ovf, udf};
        n_checks++;
        if (got !== exp_v) begin
            n_errors++;
            $display("FAIL %s: a=%b b=%b actual=%b/%b/%b expected=%b/%b/%b",
                     req, a, b, got[7:2], got[1], got[0], exp_v[7:2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic run_case(input string req, input logic [5:0] a, input logic [5:0] b,
                            input logic [7:0] exp_v);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
        check(req, a, b, exp_v);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R2", op_a, op_b, 8'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        run_case("R1", 6'b001000, 6'b001000, {6'b010000, 2'b00});
        @(negedge clk);
        op_a = 6'b001111;
        op_b = 6'b010010;
        #1;
        check("R1", op_a, op_b, {6'b010000, 2'b00});   // not yet clocked
        @(negedge clk);
        check("R1", op_a, op_b, {6'b011001, 2'b00});
    endtask

    task automatic t_same_sign();
        run_case("R4", 6'b001111, 6'b010010, {6'b011001, 2'b00});
        run_case("R4", 6'b001000, 6'b001000, {6'b010000, 2'b00});
    endtask

    task automatic t_zero();
        run_case("R3", 6'b000000, 6'b010010, {6'b010010, 2'b00});
        run_case("R3", 6'b101101, 6'b100000, {6'b101101, 2'b00});
        run_case("R3", 6'b100000, 6'b100000, {6'b100000, 2'b00});
        run_case("R3", 6'b000000, 6'b100000, {6'b000000, 2'b00});
    endtask

    task automatic t_round();
        run_case("R5", 6'b000001, 6'b001011, {6'b010000, 2'b00});  // tie up to even
        run_case("R5", 6'b001000, 6'b001001, {6'b010000, 2'b00});  // tie down to even
        run_case("R5", 6'b001111, 6'b000001, {6'b010010, 2'b00});  // nearest
    endtask

    task automatic t_subtract();
        run_case("R6", 6'b010001, 6'b101000, {6'b001010, 2'b00});
        run_case("R6", 6'b001000, 6'b110001, {6'b101010, 2'b00});
        run_case("R6", 6'b011000, 6'b101001, {6'b010100, 2'b00});  // tie after left shift
    endtask

    task automatic t_cancel();
        run_case("R7", 6'b010110, 6'b110110, 8'd0);
        run_case("R7", 6'b100011, 6'b000011, 8'd0);
    endtask

    task automatic t_overflow();
        run_case("R8", 6'b011111, 6'b011111, {6'b011111, 2'b10});
        run_case("R8", 6'b111111, 6'b111100, {6'b111111, 2'b10});
        run_case("R8", 6'b011110, 6'b000001, {6'b011111, 2'b00});  // 7.5625 stays
        run_case("R8", 6'b011111, 6'b000001, {6'b011111, 2'b10});
    endtask

    task automatic t_underflow();
        run_case("R9", 6'b001000, 6'b100111, {6'b000000, 2'b01});
        run_case("R9", 6'b100111, 6'b000110, {6'b100000, 2'b01});
        run_case("R9", 6'b001001, 6'b100001, {6'b000001, 2'b00});  // 0.5625 kept
        run_case("R9", 6'b001000, 6'b100001, {6'b000000, 2'b01});
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                run_case("R1 sweep", 6'(i), 6'(j), ref_add(6'(i), 6'(j)));
                n_checks++;
                if (ovf && udf) begin
                    n_errors++;
                    $display("FAIL R10: a=%0d b=%0d actual ovf=%b udf=%b expected not both",
                             i, j, ovf, udf);
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_same_sign();
        t_zero();
        t_round();
        t_subtract();
        t_cancel();
        t_overflow();
        t_underflow();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule